// File: doc/BRIEF.md
# Dual 8-bit Interval Timer with 16-bit Chaining

This block holds two 8-bit clear-on-match interval timers. Each channel picks one of several shared prescaler tick strobes as its count clock, counts up once per selected tick, and when its count equals its compare byte it returns to zero and raises a one-cycle interrupt pulse. The channels then run on their own, each with its own enable, tick select, compare byte and interrupt.

When the chaining mode input is 1, the two channels act as one 16-bit interval timer. The lower channel's compare byte forms bits 7:0 of the interval and the upper channel's compare byte forms bits 15:8. The lower channel's tick select drives the whole count. Only the lower interrupt stays live. To start, software raises the upper enable and then the lower enable. To stop, it drops them in the reverse order. Compare bytes are loaded through a small write port. A write that lands while its channel is running is dropped.

The block has no streaming data path. All pins are plain control and status levels or strobes, with no valid/ready handshake.

Top module: `cascade_timer`

## Requirements
- R1: After reset both counts read 0 and both interrupt outputs are 0; both compare bytes reset to 0.
- R2: With chaining off (`cascade_i`=0), an enabled channel with compare byte C counts 0..C on its selected ticks and pulses its interrupt every C+1 ticks; this includes C=FFh (256 ticks).
- R3: A channel's tick select value k makes it count on `tick_i[k]` only.
- R4: With chaining on, the interrupt on `irq_lo_o` repeats every N+1 ticks, where N = {upper compare byte, lower compare byte}; this includes N=0000h.
- R5: With chaining on, the lower count wraps from FFh to 00h and the upper count increments on that same tick.
- R6: With chaining on, `sel_hi_i` has no effect on the interval.
- R7: With chaining on, `irq_hi_o` stays 0.
- R8: The lower count is held at 0 while `en_lo_i`=0; with chaining on, counting happens only while both enables are 1, and otherwise both counts hold at 0.
- R9: A compare write (`cfg_we_i`=1; `cfg_hi_i`=0 selects the lower byte, 1 the upper) is dropped if the addressed channel is running. In chained mode, the addressed channel counts as running whenever either enable is 1. A write made while stopped takes effect.
- R10: Each interrupt is high for one system-clock cycle and rises on the same edge that clears the count, so the count reads 0 while the interrupt is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | NSEL | Shared prescaler tick strobes, one cycle each |
| cascade_i | input | 1 | 1 = chain both channels into a 16-bit timer |
| en_lo_i | input | 1 | Lower channel enable |
| en_hi_i | input | 1 | Upper channel enable |
| sel_lo_i | input | SELW | Lower channel tick select |
| sel_hi_i | input | SELW | Upper channel tick select (unused when chained) |
| cfg_we_i | input | 1 | Compare byte write strobe |
| cfg_hi_i | input | 1 | Write target: 0 lower byte, 1 upper byte |
| cfg_data_i | input | W | Compare byte write data |
| cnt_lo_o | output | W | Lower channel count |
| cnt_hi_o | output | W | Upper channel count |
| irq_lo_o | output | 1 | Lower (or chained) interrupt pulse |
| irq_hi_o | output | 1 | Upper interrupt pulse, 0 when chained |

## Verification
The bench builds the block with its defaults: 8-bit channels and four tick strobes. It drives the strobes at periods of 1, 2, 3 and 5 cycles, so each select value gives a different interval and a wrong tap or a stray upper select shows up as a wrong gap. The 8-bit width keeps a chained interval above 256 within a few hundred cycles, so the carry from the lower byte into the upper byte and the split compare can be checked. The width also allows the full-byte standalone boundary to be checked.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  typedef enum logic {
    CH_LO = 1'b0,
    CH_HI = 1'b1
  } ctmr_chan_e;
endpackage

// File: rtl/ctmr_tick_sel.sv
module ctmr_tick_sel #(
  parameter int NSEL = 4,
  parameter int SELW = $clog2(NSEL)
) (
  input  logic [NSEL-1:0] tick_i,
  input  logic [SELW-1:0] sel_i,
  output logic            tick_o
);
  always_comb begin
    tick_o = 1'b0;
    for (int k = 0; k < NSEL; k++)
      if (sel_i == SELW'(k)) tick_o = tick_i[k];
  end
endmodule

// File: rtl/ctmr_cmp_reg.sv
module ctmr_cmp_reg
  import ctmr_pkg::*;
#(
  parameter int         W  = 8,
  parameter ctmr_chan_e ID = CH_LO
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic         target_i,
  input  logic [W-1:0] data_i,
  input  logic         busy_i,
  output logic [W-1:0] cmp_o
);
  logic hit;
  assign hit = we_i && (target_i == logic'(ID)) && !busy_i;

  always_ff @(posedge clk) begin
    if (!rst_n)   cmp_o <= '0;
    else if (hit) cmp_o <= data_i;
  end

  // R9: compare byte is frozen across running cycles
  p_cmp_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_i) && busy_i) |-> $stable(cmp_o));
endmodule

// File: rtl/ctmr_chan.sv
module ctmr_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         wrap_i,
  input  logic         step_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_o <= '0;
    else if (clr_i || wrap_i)  cnt_o <= '0;
    else if (step_i)           cnt_o <= cnt_o + 1'b1;
  end

  // R2: a plain step advances the count by exactly one
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clr_i && !wrap_i) |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
  import ctmr_pkg::*;
#(
  parameter int W    = 8,
  parameter int NSEL = 4,
  parameter int SELW = $clog2(NSEL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSEL-1:0] tick_i,
  input  logic            cascade_i,
  input  logic            en_lo_i,
  input  logic            en_hi_i,
  input  logic [SELW-1:0] sel_lo_i,
  input  logic [SELW-1:0] sel_hi_i,
  input  logic            cfg_we_i,
  input  logic            cfg_hi_i,
  input  logic [W-1:0]    cfg_data_i,
  output logic [W-1:0]    cnt_lo_o,
  output logic [W-1:0]    cnt_hi_o,
  output logic            irq_lo_o,
  output logic            irq_hi_o
);
  localparam logic [W-1:0] TOP = '1;

  logic         tk_lo, tk_hi;
  logic [W-1:0] cmp_lo, cmp_hi;
  logic         match_lo, match_hi, match_w;
  logic         run_w;
  logic         busy_lo, busy_hi;
  logic         clr_lo, clr_hi, wrap_lo, wrap_hi, step_lo, step_hi;
  logic         irq_lo_d, irq_hi_d;

  ctmr_tick_sel #(.NSEL(NSEL), .SELW(SELW)) u_sel_lo (
    .tick_i(tick_i), .sel_i(sel_lo_i), .tick_o(tk_lo));
  ctmr_tick_sel #(.NSEL(NSEL), .SELW(SELW)) u_sel_hi (
    .tick_i(tick_i), .sel_i(sel_hi_i), .tick_o(tk_hi));

  ctmr_cmp_reg #(.W(W), .ID(CH_LO)) u_cmp_lo (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .target_i(cfg_hi_i),
    .data_i(cfg_data_i), .busy_i(busy_lo), .cmp_o(cmp_lo));
  ctmr_cmp_reg #(.W(W), .ID(CH_HI)) u_cmp_hi (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .target_i(cfg_hi_i),
    .data_i(cfg_data_i), .busy_i(busy_hi), .cmp_o(cmp_hi));

  assign match_lo = (cnt_lo_o == cmp_lo);
  assign match_hi = (cnt_hi_o == cmp_hi);
  assign match_w  = match_lo && match_hi;
  assign run_w    = en_lo_i && en_hi_i;

  always_comb begin
    if (cascade_i) begin
      busy_lo  = en_lo_i || en_hi_i;
      busy_hi  = busy_lo;
      clr_lo   = !run_w;
      clr_hi   = !run_w;
      wrap_lo  = tk_lo && match_w;
      wrap_hi  = wrap_lo;
      step_lo  = tk_lo && !match_w;
      step_hi  = step_lo && (cnt_lo_o == TOP);
      irq_lo_d = run_w && tk_lo && match_w;
      irq_hi_d = 1'b0;
    end else begin
      busy_lo  = en_lo_i;
      busy_hi  = en_hi_i;
      clr_lo   = !en_lo_i;
      clr_hi   = !en_hi_i;
      wrap_lo  = tk_lo && match_lo;
      wrap_hi  = tk_hi && match_hi;
      step_lo  = tk_lo && !match_lo;
      step_hi  = tk_hi && !match_hi;
      irq_lo_d = en_lo_i && tk_lo && match_lo;
      irq_hi_d = en_hi_i && tk_hi && match_hi;
    end
  end

  ctmr_chan #(.W(W)) u_chan_lo (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_lo), .wrap_i(wrap_lo),
    .step_i(step_lo), .cnt_o(cnt_lo_o));
  ctmr_chan #(.W(W)) u_chan_hi (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_hi), .wrap_i(wrap_hi),
    .step_i(step_hi), .cnt_o(cnt_hi_o));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_lo_o <= 1'b0;
      irq_hi_o <= 1'b0;
    end else begin
      irq_lo_o <= irq_lo_d;
      irq_hi_o <= irq_hi_d;
    end
  end

  // R10: count reads zero whenever the interrupt is high
  p_irq_at_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo_o |-> (cnt_lo_o == '0));
  // R7: upper interrupt silent while chained
  p_hi_muted_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cascade_i) |-> !irq_hi_o);
  // R8: lower count held at zero while its enable is low
  p_hold_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_lo_i |=> (cnt_lo_o == '0));
  // R5: chained upper byte moves only as the lower byte leaves FFh
  p_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade_i && run_w && (cnt_hi_o != '0) && $past(cascade_i && run_w)
     && !$stable(cnt_hi_o)) |-> ($past(cnt_lo_o) == TOP));
endmodule

// File: tb/test_cascade_timer.sv
module test_cascade_timer;
  localparam int W = 8, NSEL = 4, SELW = 2, LIM = 5000;

  logic clk = 0, rst_n = 0;
  logic [NSEL-1:0] tick = '0;
  logic cascade = 0, en_lo = 0, en_hi = 0, we = 0, whi = 0;
  logic [SELW-1:0] sel_lo = '0, sel_hi = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] cnt_lo, cnt_hi;
  logic irq_lo, irq_hi;
  int checks = 0, errors = 0, cyc = 0, ph = 0;
  bit hi_seen = 0;

  always #2.5 clk = ~clk;

  cascade_timer #(.W(W), .NSEL(NSEL), .SELW(SELW)) i_cascade_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .cascade_i(cascade),
    .en_lo_i(en_lo), .en_hi_i(en_hi), .sel_lo_i(sel_lo), .sel_hi_i(sel_hi),
    .cfg_we_i(we), .cfg_hi_i(whi), .cfg_data_i(wdata),
    .cnt_lo_o(cnt_lo), .cnt_hi_o(cnt_hi), .irq_lo_o(irq_lo), .irq_hi_o(irq_hi));

  always @(negedge clk) begin
    ph <= ph + 1;
    tick[0] <= 1'b1;
    tick[1] <= (ph % 2) == 0;
    tick[2] <= (ph % 3) == 0;
    tick[3] <= (ph % 5) == 0;
    cyc <= cyc + 1;
    if (cascade && irq_hi) hi_seen <= 1;
    if (cyc > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<190000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(bit hi, logic [W-1:0] d);
    @(negedge clk); we = 1; whi = hi; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic stop_all();
    @(negedge clk); en_lo = 0;
    @(negedge clk); en_hi = 0;
    @(negedge clk);
  endtask

  task automatic start_all();
    @(negedge clk); en_hi = 1;
    @(negedge clk); en_lo = 1;
  endtask

  // gap in cycles between two successive interrupt pulses; also checks width and count
  task automatic gap(bit hi, string req, int exp);
    int c = 0, g = 0;
    logic irq;
    do begin @(negedge clk); c++; irq = hi ? irq_hi : irq_lo; end while (!irq && c < LIM);
    chk({req, " count zero at irq (R10)"}, hi ? int'(cnt_hi) : int'(cnt_lo), 0);
    @(negedge clk); g = 1; irq = hi ? irq_hi : irq_lo;
    if (exp > 1) chk("R10 pulse width one cycle", int'(irq), 0);
    while (!irq && g < LIM) begin @(negedge clk); g++; irq = hi ? irq_hi : irq_lo; end
    chk(req, g, exp);
  endtask

  task automatic t_reset();
    chk("R1 cnt_lo", cnt_lo, 0); chk("R1 cnt_hi", cnt_hi, 0);
    chk("R1 irq_lo", irq_lo, 0); chk("R1 irq_hi", irq_hi, 0);
  endtask

  task automatic t_standalone();
    cascade = 0; sel_lo = 0; sel_hi = 2;
    wr(0, 8'd4); wr(1, 8'd2);
    start_all();
    gap(0, "R2 lo C=4 tick/1", 5);
    gap(1, "R2 R3 hi C=2 tick/3", 9);
    stop_all();
    sel_lo = 3; wr(0, 8'd1); start_all();
    gap(0, "R3 lo C=1 tick/5", 10);
    stop_all();
    sel_lo = 0; wr(0, 8'hFF); start_all();
    gap(0, "R2 lo C=FF boundary", 256);
    stop_all();
  endtask

  task automatic t_cascade();
    cascade = 1; sel_lo = 0; sel_hi = 3; hi_seen = 0;
    wr(0, 8'h02); wr(1, 8'h01);
    start_all();
    gap(0, "R4 R6 N=0102h", 259);
    chk("R7 irq_hi muted", int'(hi_seen), 0);
    stop_all();
    sel_lo = 1; wr(0, 8'h03); wr(1, 8'h00); start_all();
    gap(0, "R4 N=3 tick/2", 8);
    stop_all();
    sel_lo = 2; wr(0, 8'h00); start_all();
    gap(0, "R4 N=0 boundary tick/3", 3);
    stop_all();
  endtask

  task automatic t_carry();
    int c = 0;
    cascade = 1; sel_lo = 0; wr(0, 8'h00); wr(1, 8'h02);
    start_all();
    do begin @(negedge clk); c++; end while (!(cnt_hi == 0 && cnt_lo == 8'hFF) && c < LIM);
    @(negedge clk);
    chk("R5 lo wraps", cnt_lo, 0);
    chk("R5 hi carries", cnt_hi, 1);
    stop_all();
  endtask

  task automatic t_hold();
    cascade = 1; sel_lo = 0; wr(0, 8'h40); wr(1, 8'h00);
    @(negedge clk); en_hi = 1;
    repeat (20) @(negedge clk);
    chk("R8 chained lo held, en_lo=0", cnt_lo, 0);
    en_hi = 0; en_lo = 1;
    repeat (20) @(negedge clk);
    chk("R8 chained held, en_hi=0", cnt_lo, 0);
    en_lo = 0; cascade = 0; en_hi = 1;
    repeat (20) @(negedge clk);
    chk("R8 standalone lo held", cnt_lo, 0);
    stop_all();
  endtask

  task automatic t_wr_ignore();
    cascade = 1; sel_lo = 0; wr(0, 8'h10); wr(1, 8'h00);
    start_all();
    wr(0, 8'h05);
    gap(0, "R9 write while running dropped", 17);
    stop_all();
    wr(0, 8'h05); start_all();
    gap(0, "R9 write while stopped applied", 6);
    stop_all();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_standalone();
    t_cascade();
    t_carry();
    t_hold();
    t_wr_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule